// File: doc/BRIEF.md
# Two-Way Set-Associative Word Cache with First-In-First-Out Replacement

This block is a read-only cache of sixteen single-word entries, arranged as eight sets of two ways. A client presents a byte address with a valid/ready handshake. The block looks the address up in the set chosen by address bits 4:2 and compares the stored tags against address bits 5 and up. One cycle after it accepts the request, it reports whether the access hit and returns the word.

On a miss the block lowers its ready output and asks a backing memory for the aligned word. When the word arrives, the block writes it into the set and releases the request port. Any empty way is filled first. Otherwise the block evicts the way that was filled earliest in that set, and hits do not change that order.

A combinational debug port takes a set number and shows both stored tags and both valid bits for that set.

Top module: `fifo2way_cache`

## Requirements
- R1: After reset every valid bit is 0, req_ready is 1, rsp_valid is 0 and mem_req is 0.
- R2: Address bits 1:0 play no part in the lookup. Any byte address within a stored word hits and returns that word. The address on mem_addr always has bits 1:0 equal to 0.
- R3: Address bits 4:2 select the set. The tag stored for a fill is the byte address shifted right by 5, and dbg_tag0/dbg_tag1 show it. Addresses with equal bits 4:2 and different upper bits are distinct entries.
- R4: A request hits when a valid way in its set holds its tag. The cycle after acceptance, rsp_valid=1, rsp_hit=1 and rsp_data holds the stored word.
- R5: A request that misses drives req_ready to 0 from the next cycle until the fill word is taken. During that time mem_req stays 1 and mem_addr stays equal to the request address with bits 1:0 cleared.
- R6: In the cycle after mem_valid is seen with mem_req high, rsp_valid=1, rsp_hit=0, rsp_data equals the returned word, and req_ready is 1 again.
- R7: A fill uses way 0 if that way is invalid, else way 1 if that way is invalid.
- R8: When both ways of a set are valid, a fill replaces the way that was filled earlier. Hits leave this order unchanged.
- R9: From reset, the byte addresses 0, 4, 64, 0, 128, 32, 12, 96, 128, 64 give miss, miss, miss, hit, then six misses. Set 0 then holds tag 2 in way 0 and tag 4 in way 1.
- R10: Each accepted request produces exactly one response, in order, and no response appears without an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Byte address to look up |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | 1 = hit, 0 = miss served by a fill |
| rsp_data | output | DATA_W | Word for the accepted address |
| mem_req | output | 1 | Fill request to backing memory |
| mem_addr | output | ADDR_W | Word-aligned byte address of the fill |
| mem_data | input | DATA_W | Word returned by backing memory |
| mem_valid | input | 1 | mem_data is valid this cycle |
| dbg_set | input | SET_W | Set selected for inspection |
| dbg_tag0 | output | ADDR_W-SET_W-2 | Tag stored in way 0 of dbg_set |
| dbg_tag1 | output | ADDR_W-SET_W-2 | Tag stored in way 1 of dbg_set |
| dbg_valid | output | 2 | Valid bits of ways 1 and 0 of dbg_set |

## Verification
A wrong replacement pointer stays hidden until the set is full. It shows only on the next miss to that set, as a wrong hit/miss flag on a later access. For this reason the bench builds hit sequences that tell first-in-first-out from least-recently-used order, and it reads the tags through the debug port after each such sequence. A wrong tag or set split shows one cycle after acceptance, as a wrong hit flag or a wrong word. A fill that lands in the wrong way shows at once on the debug port. A stuck handshake shows as a missing response.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
    localparam int CFC_OFF_W = 2;   // byte offset within a 4-byte word
    localparam int CFC_WAYS  = 2;

    typedef enum logic {
        CS_IDLE = 1'b0,
        CS_FILL = 1'b1
    } cfc_state_e;
endpackage

// File: rtl/cfc_set_store.sv
module cfc_set_store
    import cfc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SET_W  = 3,
    localparam int SETS  = 1 << SET_W,
    localparam int TAG_W = ADDR_W - SET_W - CFC_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              fill_en,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [SET_W-1:0]  dbg_set,
    output logic [TAG_W-1:0]  dbg_tag0,
    output logic [TAG_W-1:0]  dbg_tag1,
    output logic [1:0]        dbg_valid
);
    typedef struct packed {
        logic [SETS-1:0][CFC_WAYS-1:0]             vld;
        logic [SETS-1:0]                           ptr;   // next victim when full
        logic [SETS-1:0][CFC_WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][CFC_WAYS-1:0][DATA_W-1:0] dat;
    } store_t;

    store_t st_d, st_q;
    logic [CFC_WAYS-1:0] match;
    logic                victim;

    for (genvar w = 0; w < CFC_WAYS; w++) begin : g_cmp
        assign match[w] = st_q.vld[lk_set][w] && (st_q.tag[lk_set][w] == lk_tag);
    end

    assign lk_hit  = |match;
    assign lk_data = match[1] ? st_q.dat[lk_set][1] : st_q.dat[lk_set][0];

    // empty ways first, then the FIFO pointer
    always_comb begin
        if (!st_q.vld[fill_set][0])      victim = 1'b0;
        else if (!st_q.vld[fill_set][1]) victim = 1'b1;
        else                             victim = st_q.ptr[fill_set];
    end

    always_comb begin
        st_d = st_q;
        if (fill_en) begin
            st_d.vld[fill_set][victim] = 1'b1;
            st_d.tag[fill_set][victim] = fill_tag;
            st_d.dat[fill_set][victim] = fill_data;
            st_d.ptr[fill_set]         = ~victim;   // the other way is now oldest
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dbg_tag0  = st_q.tag[dbg_set][0];
    assign dbg_tag1  = st_q.tag[dbg_set][1];
    assign dbg_valid = st_q.vld[dbg_set];

    // a tag never sits in both ways of one set
    assert_unique_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // a fill always leaves its target set with a valid way holding the new tag
    assert_fill_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (st_q.vld[$past(fill_set)] != 2'b00));
endmodule

// File: rtl/cfc_ctrl.sv
module cfc_ctrl
    import cfc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              mem_valid,
    output logic              fill_en,
    output logic [ADDR_W-1:0] fill_addr
);
    typedef struct packed {
        cfc_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              rvld;
        logic              rhit;
        logic [DATA_W-1:0] rdat;
    } ctl_t;

    ctl_t c_d, c_q;
    logic accept;

    assign req_ready = (c_q.state == CS_IDLE);
    assign accept    = req_valid && req_ready;
    assign fill_en   = (c_q.state == CS_FILL) && mem_valid;

    always_comb begin
        c_d      = c_q;
        c_d.rvld = 1'b0;
        unique case (c_q.state)
            CS_IDLE: begin
                if (req_valid) begin
                    if (lk_hit) begin
                        c_d.rvld = 1'b1;
                        c_d.rhit = 1'b1;
                        c_d.rdat = lk_data;
                    end else begin
                        c_d.state = CS_FILL;
                        c_d.addr  = {req_addr[ADDR_W-1:CFC_OFF_W], {CFC_OFF_W{1'b0}}};
                    end
                end
            end
            CS_FILL: begin
                if (mem_valid) begin
                    c_d.state = CS_IDLE;
                    c_d.rvld  = 1'b1;
                    c_d.rhit  = 1'b0;
                    c_d.rdat  = mem_data;
                end
            end
            default: c_d.state = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rsp_valid = c_q.rvld;
    assign rsp_hit   = c_q.rhit;
    assign rsp_data  = c_q.rdat;
    assign mem_req   = (c_q.state == CS_FILL);
    assign mem_addr  = c_q.addr;
    assign fill_addr = c_q.addr;

    assert_miss_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !lk_hit) |=> (!req_ready && mem_req));

    assert_fill_addr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));

    assert_hit_response_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_hit) |=> (rsp_valid && rsp_hit && rsp_data == $past(lk_data)));

    assert_fill_response_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |=> (rsp_valid && !rsp_hit && req_ready
                                    && rsp_data == $past(mem_data)));

    assert_resp_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past((accept && lk_hit) || (mem_req && mem_valid)));
endmodule

// File: rtl/fifo2way_cache.sv
module fifo2way_cache
    import cfc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SET_W  = 3,
    localparam int TAG_W = ADDR_W - SET_W - CFC_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              mem_valid,
    input  logic [SET_W-1:0]  dbg_set,
    output logic [TAG_W-1:0]  dbg_tag0,
    output logic [TAG_W-1:0]  dbg_tag1,
    output logic [1:0]        dbg_valid
);
    localparam int TAG_LO = CFC_OFF_W + SET_W;

    logic              lk_hit, fill_en;
    logic [DATA_W-1:0] lk_data;
    logic [ADDR_W-1:0] fill_addr;

    cfc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk, .rst_n, .req_valid, .req_addr, .req_ready,
        .lk_hit, .lk_data,
        .rsp_valid, .rsp_hit, .rsp_data,
        .mem_req, .mem_addr, .mem_data, .mem_valid,
        .fill_en, .fill_addr
    );

    cfc_set_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_W)) u_store (
        .clk, .rst_n,
        .lk_set   (req_addr[TAG_LO-1:CFC_OFF_W]),
        .lk_tag   (req_addr[ADDR_W-1:TAG_LO]),
        .lk_hit, .lk_data,
        .fill_en,
        .fill_set (fill_addr[TAG_LO-1:CFC_OFF_W]),
        .fill_tag (fill_addr[ADDR_W-1:TAG_LO]),
        .fill_data(mem_data),
        .dbg_set, .dbg_tag0, .dbg_tag1, .dbg_valid
    );
endmodule

// File: tb/sim_fifo2way_cache.sv
module sim_fifo2way_cache;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = 3;
    localparam int TW = AW - SW - 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, mem_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] mem_data = '0;
    logic [SW-1:0] dbg_set = '0;
    logic req_ready, rsp_valid, rsp_hit, mem_req;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] mem_addr;
    logic [TW-1:0] dbg_tag0, dbg_tag1;
    logic [1:0] dbg_valid;

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    logic [AW-1:0] last_addr = '0;
    logic [DW:0] exp_q[$];
    string lbl_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo2way_cache #(.ADDR_W(AW), .DATA_W(DW), .SET_W(SW)) u0 (.*);

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return (a * 32'd7) ^ 32'h5A00_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic eh, input string lbl);
        exp_q.push_back({eh, mem_word({a[AW-1:2], 2'b00})});
        lbl_q.push_back(lbl);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready) @(negedge clk);
        last_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic look(input int s, input logic [1:0] ev, input logic [TW-1:0] t0,
                        input logic [TW-1:0] t1, input string req);
        @(negedge clk);
        dbg_set = s[SW-1:0];
        #1;
        chk(dbg_valid == ev, req, dbg_valid, ev);
        if (ev[0]) chk(dbg_tag0 == t0, req, dbg_tag0, t0);
        if (ev[1]) chk(dbg_tag1 == t1, req, dbg_tag1, t1);
    endtask

    // monitor: compare each response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected response", rsp_data, 0);
            end else begin
                logic [DW:0] e;
                string l;
                e = exp_q.pop_front();
                l = lbl_q.pop_front();
                chk(rsp_hit == e[DW], {l, " hit flag"}, rsp_hit, e[DW]);
                chk(rsp_data == e[DW-1:0], {l, " data"}, rsp_data, e[DW-1:0]);
                if (!rsp_hit) chk(req_ready, "R6 ready back with fill response", req_ready, 1);
            end
        end
    end

    // backing memory: two cycles of latency
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req && !mem_valid) begin
                chk(mem_addr == {last_addr[AW-1:2], 2'b00}, "R2 R5 fill address aligned",
                    mem_addr, {last_addr[AW-1:2], 2'b00});
                repeat (2) @(negedge clk);
                chk(!req_ready && mem_req, "R5 stalled during fill", req_ready, 0);
                mem_data  = mem_word(mem_addr);
                mem_valid = 1'b1;
                @(negedge clk);
                mem_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !rsp_valid && !mem_req, "R1 ports after reset",
            {req_ready, rsp_valid, mem_req}, 3'b100);
        for (int s = 0; s < 8; s++) look(s, 2'b00, '0, '0, "R1 valid cleared");

        // R9 directed sequence
        issue(0,   0, "R9 a0");
        issue(4,   0, "R9 a4");
        issue(64,  0, "R9 a64");
        issue(0,   1, "R9 a0 again");
        issue(128, 0, "R9 a128");
        issue(32,  0, "R9 a32");
        issue(12,  0, "R9 a12");
        issue(96,  0, "R9 a96");
        issue(128, 0, "R9 a128 again");
        issue(64,  0, "R9 a64 again");
        drain();
        look(0, 2'b11, 27'd2, 27'd4, "R9 set0 final");
        look(1, 2'b01, 27'd0, '0, "R3 set1 holds word 1");
        look(3, 2'b01, 27'd0, '0, "R3 set3 holds word 3");
        look(2, 2'b00, '0, '0, "R3 set2 untouched");

        // R2 byte offset ignored
        issue(66,  1, "R2 byte 2 of word 64");
        issue(131, 1, "R2 byte 3 of word 128");

        // R7 empty ways first, R8 FIFO order ignores hits (set 5)
        issue(20, 0, "R7 first fill set5");
        issue(52, 0, "R7 second fill set5");
        drain();
        look(5, 2'b11, 27'd0, 27'd1, "R7 way order set5");
        issue(20, 1, "R8 hit on oldest");
        issue(84, 0, "R8 miss evicts oldest");
        issue(52, 1, "R8 younger survives");
        issue(20, 0, "R8 oldest was evicted");
        drain();
        look(5, 2'b11, 27'd2, 27'd0, "R8 set5 contents");

        // R3 upper tag bits separate same-set addresses
        issue(32'h8000_001C, 0, "R3 high tag set7");
        issue(32'h0000_001C, 0, "R3 low tag set7");
        issue(32'h8000_001D, 1, "R3 high tag still present");
        drain();
        look(7, 2'b11, 27'h400_0000, 27'd0, "R3 set7 tags");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0 && !rsp_valid, "R10 no stray responses", exp_q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule